// File: doc/BRIEF.md
# Deferred-Write Peripheral Register Decoder

This block turns a small register-select address and active-low CPU read and write requests into one-hot, active-high read and write strobes. It serves a dual-port peripheral that has three registers per port: a control register, a direction register and a data register. Address decoding follows a two-phase bus clock, which reaches the block as a level (`phase_hi`) and is sampled on the fast system clock.

Reads decode the live address during the high phase. Writes work differently. Address and request are captured while the phase is high and held once it falls. The write strobe comes one system clock after the block first sees the phase low. It stays up until the phase rises again, and it is forced off for the whole high phase. In each port, the even address reaches the direction register or the data register, chosen by a select bit taken from that port's control register. Both read and write decodes use the select bit's current value.

Top module: `defer_reg_decoder`

## Requirements
- R1: Address 1 reaches port A's control register (strobe bit 0) and address 3 reaches port B's control register (strobe bit 3), for reads and writes alike.
- R2: Address 0 reaches port A's direction register (bit 1) when `ctl_sel[0]` is 0, and port A's data register (bit 2) when it is 1.
- R3: Address 2 reaches port B's direction register (bit 4) when `ctl_sel[1]` is 0, and port B's data register (bit 5) when it is 1.
- R4: `rd_en` is nonzero only while `phase_hi`, `chip_sel` are high and `rd_n` is low. It is decoded combinationally from the live `addr` and `ctl_sel`.
- R5: At every clock edge with `phase_hi` high, the write address and the write request (`chip_sel` high and `wr_n` low) are captured. The captured values hold while `phase_hi` is low, so the last value seen in the high phase wins.
- R6: `wr_en` is all zero whenever `phase_hi` is high.
- R7: A captured write request raises `wr_en` from the first clock edge at which `phase_hi` is seen low, and not before. `wr_en` then stays up for the rest of that low interval.
- R8: At most one bit of `rd_en` and at most one bit of `wr_en` is set at any time. With `chip_sel` low, no read strobe is given and no write is captured.
- R9: The write decode uses the `ctl_sel` value present while the strobe is up, so a select change during the low phase moves the strobe.
- R10: A synchronous active-low reset clears the captured write request, so no write strobe follows reset until a new write is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_hi | input | 1 | Bus clock phase level, high during the active phase |
| chip_sel | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read request, active low |
| wr_n | input | 1 | Write request, active low |
| addr | input | 2 | Register-select address |
| ctl_sel | input | 2 | Bit 2 of each port's control register (bit 0 port A, bit 1 port B) |
| rd_en | output | 6 | One-hot read strobes: 0 ctl A, 1 dir A, 2 data A, 3 ctl B, 4 dir B, 5 data B |
| wr_en | output | 6 | One-hot write strobes, same bit order as `rd_en` |

## Verification
A pending write strobe in the low phase and a change of the port's select bit can fall in the same cycle. When that happens, the strobe must move between the direction register and the data register at once. The bench provokes this by toggling `ctl_sel` in the middle of the low interval after a write to address 0 or 2. It also issues a read and a write together in one high phase, and changes the address on the last high clock. A behavioural model run alongside the design judges every cycle. It predicts both strobe vectors from the captured request, the held address and the live select bits.

// File: rtl/defer_reg_decoder_pkg.sv
// Shared definitions for the deferred-write register decoder.
// Assumes three registers per port, laid out as control, direction, data.
package defer_reg_decoder_pkg;

    // Register kind within one port; its value is the offset inside the port's group.
    typedef enum logic [1:0] {
        KIND_CTL  = 2'd0,
        KIND_DIR  = 2'd1,
        KIND_DATA = 2'd2
    } reg_kind_e;

    localparam int REGS_PER_PORT = 3;

    // Position of a register's strobe in the flattened strobe vector.
    function automatic int strobe_slot(input int port, input reg_kind_e kind);
        return port * REGS_PER_PORT + int'(kind);
    endfunction

endpackage

// File: rtl/regsel_decode.sv
// Address-to-strobe decoder for NPORT ports.
// Port p owns address 2p+1 (control register) and address 2p, which goes to the
// direction register when sel_bits[p] is 0 and to the data register when it is 1.
// Assumes: en is already qualified by phase and request; the output is purely combinational.
module regsel_decode
    import defer_reg_decoder_pkg::*;
#(
    parameter int NPORT = 2,
    localparam int AW   = (2 * NPORT > 1) ? $clog2(2 * NPORT) : 1,
    localparam int NREG = REGS_PER_PORT * NPORT
) (
    input  logic             en,
    input  logic [AW-1:0]    addr,
    input  logic [NPORT-1:0] sel_bits,
    output logic [NREG-1:0]  strobe
);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic hit_ctl;
        logic hit_side;

        // Match this port's two addresses.
        always_comb begin
            hit_ctl  = (addr == AW'(2 * p + 1));
            hit_side = (addr == AW'(2 * p));
        end

        // Route the match onto this port's three strobes.
        always_comb begin
            strobe[strobe_slot(p, KIND_CTL)]  = en & hit_ctl;
            strobe[strobe_slot(p, KIND_DIR)]  = en & hit_side & ~sel_bits[p];
            strobe[strobe_slot(p, KIND_DATA)] = en & hit_side &  sel_bits[p];
        end
    end

endmodule

// File: rtl/wr_capture.sv
// Write-side capture stage. It follows address and request at each clock while the
// bus phase is high, like a transparent latch, and holds them while the phase is low.
// A one-clock qualification arms the write only after the phase has been seen low.
// Assumes phase_hi is synchronous to clk.
module wr_capture #(
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_hi,
    input  logic          req,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] held_addr,
    output logic          armed
);

    logic pending;

    // Follow address and request during the high phase, hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            pending   <= 1'b0;
        end else if (phase_hi) begin
            held_addr <= addr;
            pending   <= req;
        end
    end

    // Arm one clock after the phase is seen low; disarm as soon as it is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (phase_hi) begin
            armed <= 1'b0;
        end else begin
            armed <= pending;
        end
    end

endmodule

// File: rtl/defer_reg_decoder.sv
// Deferred-write peripheral register decoder (top).
// Reads decode the live address while the bus phase is high. Writes decode the
// address captured in the high phase and strobe in the following low phase.
// Assumes all inputs are synchronous to clk; strobes are active high.
module defer_reg_decoder
    import defer_reg_decoder_pkg::*;
#(
    parameter int NPORT = 2,
    localparam int AW   = (2 * NPORT > 1) ? $clog2(2 * NPORT) : 1,
    localparam int NREG = REGS_PER_PORT * NPORT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_hi,
    input  logic             chip_sel,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [AW-1:0]    addr,
    input  logic [NPORT-1:0] ctl_sel,
    output logic [NREG-1:0]  rd_en,
    output logic [NREG-1:0]  wr_en
);

    logic          rd_go;
    logic          wr_req;
    logic          wr_go;
    logic          wr_armed;
    logic [AW-1:0] wr_addr;

    // Qualify the read and write requests with chip select and phase.
    always_comb begin
        rd_go  = phase_hi & chip_sel & ~rd_n;
        wr_req = chip_sel & ~wr_n;
        wr_go  = wr_armed & ~phase_hi;
    end

    regsel_decode #(.NPORT(NPORT)) u_rd_dec (
        .en       (rd_go),
        .addr     (addr),
        .sel_bits (ctl_sel),
        .strobe   (rd_en)
    );

    wr_capture #(.AW(AW)) u_wr_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_hi  (phase_hi),
        .req       (wr_req),
        .addr      (addr),
        .held_addr (wr_addr),
        .armed     (wr_armed)
    );

    regsel_decode #(.NPORT(NPORT)) u_wr_dec (
        .en       (wr_go),
        .addr     (wr_addr),
        .sel_bits (ctl_sel),
        .strobe   (wr_en)
    );

endmodule

// File: rtl/defer_reg_decoder_chk.sv
// Protocol checker for defer_reg_decoder, attached by bind.
// Assumes the default register layout of three strobes per port.
module defer_reg_decoder_chk #(
    parameter int NPORT = 2,
    localparam int AW   = (2 * NPORT > 1) ? $clog2(2 * NPORT) : 1,
    localparam int NREG = 3 * NPORT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phase_hi,
    input logic             chip_sel,
    input logic             rd_n,
    input logic [AW-1:0]    addr,
    input logic [NPORT-1:0] ctl_sel,
    input logic [NREG-1:0]  rd_en,
    input logic [NREG-1:0]  wr_en
);

    // R8: one-hot strobes
    p_rd_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rd_en));
    p_wr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_en));

    // R4: reads only in the qualified high phase
    p_rd_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en != '0) |-> (phase_hi && chip_sel && !rd_n));

    // R6: no write strobe in the high phase
    p_wr_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        phase_hi |-> (wr_en == '0));

    // R7: no write strobe at the first edge that sees the phase low
    p_wr_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phase_hi) |-> (wr_en == '0));

    // R10: nothing is armed straight after reset
    p_wr_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (wr_en == '0));

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        // R1: control register strobe only at its odd address
        p_rd_ctl_r1: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en[3*p] |-> (addr == AW'(2 * p + 1)));
        // R2, R3: direction register only at the even address with select clear
        p_rd_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en[3*p+1] |-> (addr == AW'(2 * p) && !ctl_sel[p]));
        // R2, R3: data register only at the even address with select set
        p_rd_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en[3*p+2] |-> (addr == AW'(2 * p) && ctl_sel[p]));
        // R9: write direction/data choice follows the live select bit
        p_wr_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[3*p+2] |-> ctl_sel[p]);
    end

endmodule

bind defer_reg_decoder defer_reg_decoder_chk #(.NPORT(NPORT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_hi (phase_hi),
    .chip_sel (chip_sel),
    .rd_n     (rd_n),
    .addr     (addr),
    .ctl_sel  (ctl_sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en)
);

// File: tb/defer_reg_decoder_test.sv
// Bench for defer_reg_decoder: behavioural model compared on every clock.
module defer_reg_decoder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_hi = 1'b0;
    logic       chip_sel = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [1:0] addr = '0;
    logic [1:0] ctl_sel = '0;
    logic [5:0] rd_en;
    logic [5:0] wr_en;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    // model state
    bit       m_pend = 0;
    bit       m_arm = 0;
    bit [1:0] m_addr = '0;

    always #5 clk = ~clk;

    defer_reg_decoder uut (
        .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi), .chip_sel(chip_sel),
        .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .ctl_sel(ctl_sel),
        .rd_en(rd_en), .wr_en(wr_en)
    );

    // Register number from address and select bits (R1, R2, R3).
    function automatic int reg_of(input bit [1:0] a, input bit [1:0] s);
        case (a)
            2'd0: return s[0] ? 2 : 1;
            2'd1: return 0;
            2'd2: return s[1] ? 5 : 4;
            default: return 3;
        endcase
    endfunction

    // Model update: capture in the high phase, arm one edge after it goes low.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_arm = 0; m_addr = '0;
        end else if (phase_hi) begin
            m_pend = chip_sel && !wr_n;
            m_addr = addr;
            m_arm  = 0;
        end else begin
            m_arm = m_pend;
        end
    end

    // Compare outputs against the model away from the active edge.
    always @(negedge clk) begin
        logic [5:0] exp_rd;
        logic [5:0] exp_wr;
        exp_rd = (phase_hi && chip_sel && !rd_n) ? 6'(1 << reg_of(addr, ctl_sel)) : 6'd0;
        exp_wr = (m_arm && !phase_hi) ? 6'(1 << reg_of(m_addr, ctl_sel)) : 6'd0;
        if (!done) begin
            n_checks++;
            if (rd_en !== exp_rd || wr_en !== exp_wr) begin
                n_fail++;
                $display("FAIL %s: rd_en=%b wr_en=%b expected rd_en=%b wr_en=%b",
                         cur_req, rd_en, wr_en, exp_rd, exp_wr);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    // One bus cycle: high phase with the given controls, then an idle low phase.
    task automatic bus(input bit cs, input bit rn, input bit wn, input bit [1:0] a,
                       input int nhi, input int nlo);
        phase_hi = 1; chip_sel = cs; rd_n = rn; wr_n = wn; addr = a;
        step(nhi);
        phase_hi = 0; chip_sel = 0; rd_n = 1; wr_n = 1;
        step(nlo);
    endtask

    initial begin
        // R10: reset with write activity on the inputs
        cur_req = "R10";
        @(posedge clk); #2;
        phase_hi = 1; chip_sel = 1; wr_n = 0; addr = 2'd1;
        step(3);
        phase_hi = 0; step(3);
        rst_n = 1;
        bus(0, 1, 1, 2'd0, 3, 3);

        // R1: control registers
        cur_req = "R1";
        bus(1, 0, 1, 2'd1, 3, 3);
        bus(1, 0, 1, 2'd3, 3, 3);
        bus(1, 1, 0, 2'd1, 3, 4);
        bus(1, 1, 0, 2'd3, 3, 4);

        // R2 and R3: select bit chooses direction or data
        for (int s = 0; s < 4; s++) begin
            ctl_sel = 2'(s);
            cur_req = "R2";
            bus(1, 0, 1, 2'd0, 2, 2);
            bus(1, 1, 0, 2'd0, 2, 3);
            cur_req = "R3";
            bus(1, 0, 1, 2'd2, 2, 2);
            bus(1, 1, 0, 2'd2, 2, 3);
        end

        // R4: read request outside the high phase and with one-clock high phase
        cur_req = "R4";
        phase_hi = 0; chip_sel = 1; rd_n = 0; addr = 2'd3; step(3);
        bus(1, 0, 1, 2'd2, 1, 2);

        // R8: deselected read and write
        cur_req = "R8";
        bus(0, 0, 1, 2'd1, 3, 3);
        bus(0, 1, 0, 2'd3, 3, 4);
        bus(1, 0, 0, 2'd1, 3, 4);

        // R5: address and request change on the last high clock
        cur_req = "R5";
        phase_hi = 1; chip_sel = 1; rd_n = 1; wr_n = 0; addr = 2'd1; step(2);
        addr = 2'd3; step(1);
        phase_hi = 0; chip_sel = 0; wr_n = 1; step(4);
        phase_hi = 1; chip_sel = 1; wr_n = 0; addr = 2'd0; step(2);
        wr_n = 1; step(1);
        phase_hi = 0; step(4);

        // R6 and R7: long low phase, then rise while armed
        cur_req = "R7";
        bus(1, 1, 0, 2'd2, 4, 8);
        cur_req = "R6";
        bus(1, 1, 0, 2'd3, 2, 3);
        bus(1, 1, 1, 2'd0, 3, 3);

        // R9: select toggles while a write strobe is up
        cur_req = "R9";
        ctl_sel = 2'b00;
        phase_hi = 1; chip_sel = 1; wr_n = 0; addr = 2'd0; step(3);
        phase_hi = 0; chip_sel = 0; wr_n = 1; step(2);
        ctl_sel = 2'b01; step(2);
        ctl_sel = 2'b00; step(1);
        phase_hi = 1; chip_sel = 1; wr_n = 0; addr = 2'd2; step(3);
        phase_hi = 0; chip_sel = 0; wr_n = 1; step(2);
        ctl_sel = 2'b10; step(2);

        // R10: reset while a strobe is armed
        cur_req = "R10";
        bus(1, 1, 0, 2'd1, 3, 2);
        rst_n = 0; step(2);
        rst_n = 1; step(3);
        bus(0, 1, 1, 2'd0, 2, 3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #500000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule